// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Register Block

This block collects sixty-four interrupt inputs and turns them into two request lines: a normal request and a fast request. Each input is first brought into the clock domain by a two-stage synchroniser. A per-source configuration then decides how the input is interpreted. It is either a level, with a selectable active value, or an edge. An edge is caught in a sticky latch on the chosen direction or on both directions. Software can force any source pending with a trigger bit. An enable mask and a routing bit decide which request line, if either, a pending source drives.

Software reaches the block through a plain 32-bit read/write strobe port. Every per-source function takes two adjacent words: the word at the function's offset holds sources 0 to 31 and the word four bytes above holds sources 32 to 63. Enables and triggers each have a separate write-one-to-set word and a separate write-one-to-clear word. A handler scans the masked status words, low word first, to find the lowest pending source. For an edge source it clears the latch through the latch-clear word before returning.

Top module: `intc_regs`

## Requirements
- R1: After reset, enables, triggers, routing bits and edge latches are all zero and both request outputs are low. The level/edge, polarity and both-edges configuration words read back their parameter reset values.
- R2: Address bit 2 picks the word: 0 addresses sources 0..31 and 1 addresses sources 32..63. Bits 6..3 pick the function: 0 normal status, 1 fast status, 2 raw pending, 3 routing, 4 enable set, 5 enable clear, 6 trigger set, 7 trigger clear, 8 level/edge, 9 both-edges, 10 polarity, 11 latch clear, 12 latch status. Routing, level/edge, both-edges and polarity words are plain read/write.
- R3: A 1 written to an enable-set bit enables that source, and a 1 written to an enable-clear bit disables it. Bits written as 0 leave the source unchanged. Both words read back the enable mask.
- R4: A 1 written to a trigger-set bit makes the source pending whatever its input does. A 1 written to the trigger-clear bit removes the trigger. Both words read back the trigger mask.
- R5: A routing bit of 0 sends a source to the normal status word and a 1 sends it to the fast status word. Normal status is pending AND enable AND NOT routing. Fast status is pending AND enable AND routing.
- R6: A source whose level/edge bit is 1 is level-sensitive. It is pending while its synchronised input equals its polarity bit, starting on the second clock edge after the input changes. It never sets its latch.
- R7: A source whose level/edge bit is 0 is edge-sensitive. With polarity 1 a rising input sets its latch, and with polarity 0 a falling input sets it. The latch reads as set from the third clock edge after the input change and holds until cleared. An edge source is pending while its latch or its trigger is set.
- R8: When the both-edges bit of an edge source is 1, either input transition sets its latch and the polarity bit is ignored.
- R9: A 1 written to a latch-clear bit clears that edge source's latch, and it has no effect on a level source. If a new edge arrives on the same clock edge as the clear, the latch stays set. The latch-clear word reads back the latch status.
- R10: The normal request output is high exactly when any normal status bit in either word is set. The fast request output is high exactly when any fast status bit is set.
- R11: The raw pending word shows each source's pending state before enable and routing are applied.
- R12: Writes to status words, to offsets beyond function 12, to addresses with bit 7 set or to addresses with bits 1..0 nonzero change nothing. Reads of those unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 64 | Asynchronous interrupt inputs, one per source |
| wrEn | input | 1 | Write strobe, one cycle per write |
| addr | input | 8 | Byte address of the word read or written |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
The bench measures input-to-status latency cycle by cycle. A level source must appear on the second edge and an edge latch on the third. A design with one synchroniser stage too few or too many shows the change one read early or late. A latch clear is aimed at the very edge on which a new transition is detected; a design that lets the clear win loses that interrupt and reads the latch as zero. Clears aimed at level sources, at the wrong word and at unmapped or misaligned addresses catch designs that decode too loosely or mask by the wrong bit. Random configuration and pin traffic, including falling-edge and both-edge sources, is compared against a bench model. A polarity or routing inversion then shows up as a mismatch in the status words or on the request lines.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 2;
  localparam int NUM_SRC   = WORD_W * NUM_WORDS;
  localparam int WSEL_W    = $clog2(NUM_WORDS);
  localparam int ADDR_W    = 8;
  localparam int WORD_BIT  = 2;
  localparam int FUNC_LSB  = WORD_BIT + WSEL_W;
  localparam int FUNC_W    = 4;
  localparam int LAST_FUNC = 12;

  // Function index carried in the address above the word-select bit.
  typedef enum logic [FUNC_W-1:0] {
    F_IRQ     = 4'd0,
    F_FIQ     = 4'd1,
    F_RAW     = 4'd2,
    F_SEL     = 4'd3,
    F_EN_SET  = 4'd4,
    F_EN_CLR  = 4'd5,
    F_TRG_SET = 4'd6,
    F_TRG_CLR = 4'd7,
    F_SENSE   = 4'd8,
    F_DUAL    = 4'd9,
    F_POL     = 4'd10,
    F_LCLR    = 4'd11,
    F_LSTAT   = 4'd12
  } func_e;

  // Write strobes from the decoder to the datapath.
  typedef struct packed {
    logic              enSet;
    logic              enClr;
    logic              trgSet;
    logic              trgClr;
    logic              selWr;
    logic              senseWr;
    logic              dualWr;
    logic              polWr;
    logic              latchClr;
    logic [WSEL_W-1:0] word;
    logic [WORD_W-1:0] data;
  } strobe_t;

  // Full per-source state as seen by the read path.
  typedef struct packed {
    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] trg;
    logic [NUM_SRC-1:0] sel;
    logic [NUM_SRC-1:0] sense;
    logic [NUM_SRC-1:0] dual;
    logic [NUM_SRC-1:0] pol;
    logic [NUM_SRC-1:0] latch;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] irqStat;
    logic [NUM_SRC-1:0] fiqStat;
  } view_t;

endpackage

// File: rtl/intc_srcsync.sv
module intc_srcsync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] srcIn,
  output logic [WIDTH-1:0] srcNow,
  output logic [WIDTH-1:0] srcPrev
);

  logic [WIDTH-1:0] stage1;

  // Two flops bring the inputs into the clock domain; a third keeps the
  // previous synchronised value for transition detection.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1  <= '0;
      srcNow  <= '0;
      srcPrev <= '0;
    end else begin
      stage1  <= srcIn;
      srcNow  <= stage1;
      srcPrev <= srcNow;
    end
  end

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter logic [NUM_SRC-1:0] SENSE_RST = '0,
  parameter logic [NUM_SRC-1:0] POL_RST   = '1,
  parameter logic [NUM_SRC-1:0] DUAL_RST  = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  strobe_t            strb,
  output view_t              view,
  output logic               irqOut,
  output logic               fiqOut
);

  logic [NUM_SRC-1:0] srcNow, srcPrev;
  logic [NUM_SRC-1:0] wrMask, wordSel;
  logic [NUM_SRC-1:0] enQ, trgQ, selQ, senseQ, dualQ, polQ, latchQ;
  logic [NUM_SRC-1:0] riseV, fallV, edgeHit, levelAct, clrMask, pendV;
  logic [NUM_SRC-1:0] irqStat, fiqStat;

  intc_srcsync #(.WIDTH(NUM_SRC)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .srcNow (srcNow),
    .srcPrev(srcPrev)
  );

  // Place the write word at its source positions.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic hit;
    assign hit = (strb.word == WSEL_W'(w));
    assign wrMask[w*WORD_W +: WORD_W]  = hit ? strb.data : '0;
    assign wordSel[w*WORD_W +: WORD_W] = {WORD_W{hit}};
  end

  // Source interpretation.
  assign riseV    = srcNow & ~srcPrev;
  assign fallV    = ~srcNow & srcPrev;
  assign edgeHit  = (dualQ & (riseV | fallV))
                  | (~dualQ & polQ & riseV)
                  | (~dualQ & ~polQ & fallV);
  assign levelAct = ~(srcNow ^ polQ);
  assign clrMask  = strb.latchClr ? (wrMask & ~senseQ) : '0;
  assign pendV    = (senseQ & levelAct) | (~senseQ & latchQ) | trgQ;

  // Set/clear registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ  <= '0;
      trgQ <= '0;
    end else begin
      if (strb.enSet)       enQ <= enQ | wrMask;
      else if (strb.enClr)  enQ <= enQ & ~wrMask;
      if (strb.trgSet)      trgQ <= trgQ | wrMask;
      else if (strb.trgClr) trgQ <= trgQ & ~wrMask;
    end
  end

  // Whole-word configuration registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ   <= '0;
      senseQ <= SENSE_RST;
      dualQ  <= DUAL_RST;
      polQ   <= POL_RST;
    end else begin
      if (strb.selWr)   selQ   <= (selQ & ~wordSel) | wrMask;
      if (strb.senseWr) senseQ <= (senseQ & ~wordSel) | wrMask;
      if (strb.dualWr)  dualQ  <= (dualQ & ~wordSel) | wrMask;
      if (strb.polWr)   polQ   <= (polQ & ~wordSel) | wrMask;
    end
  end

  // Edge latches: a fresh edge takes precedence over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN) latchQ <= '0;
    else       latchQ <= (latchQ & ~clrMask) | (edgeHit & ~senseQ);
  end

  assign irqStat = pendV & enQ & ~selQ;
  assign fiqStat = pendV & enQ & selQ;
  assign irqOut  = |irqStat;
  assign fiqOut  = |fiqStat;

  assign view.en      = enQ;
  assign view.trg     = trgQ;
  assign view.sel     = selQ;
  assign view.sense   = senseQ;
  assign view.dual    = dualQ;
  assign view.pol     = polQ;
  assign view.latch   = latchQ;
  assign view.pend    = pendV;
  assign view.irqStat = irqStat;
  assign view.fiqStat = fiqStat;

endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  input  view_t             view,
  output strobe_t           strb,
  output logic [WORD_W-1:0] rdData
);

  logic [FUNC_W-1:0]  funcIdx;
  logic [WSEL_W-1:0]  wordIdx;
  logic               addrOk;
  func_e              funcSel;
  logic [NUM_SRC-1:0] rdVec;
  logic [WORD_W-1:0]  rdWords [NUM_WORDS];

  assign funcIdx = addr[FUNC_LSB +: FUNC_W];
  assign wordIdx = addr[WORD_BIT +: WSEL_W];
  assign funcSel = func_e'(funcIdx);
  assign addrOk  = (addr[WORD_BIT-1:0] == '0)
                && (addr[ADDR_W-1:FUNC_LSB+FUNC_W] == '0)
                && (int'(funcIdx) <= LAST_FUNC);

  // Write decode.
  always_comb begin
    strb      = '0;
    strb.word = wordIdx;
    strb.data = wrData;
    if (wrEn && addrOk) begin
      case (funcSel)
        F_EN_SET:  strb.enSet    = 1'b1;
        F_EN_CLR:  strb.enClr    = 1'b1;
        F_TRG_SET: strb.trgSet   = 1'b1;
        F_TRG_CLR: strb.trgClr   = 1'b1;
        F_SEL:     strb.selWr    = 1'b1;
        F_SENSE:   strb.senseWr  = 1'b1;
        F_DUAL:    strb.dualWr   = 1'b1;
        F_POL:     strb.polWr    = 1'b1;
        F_LCLR:    strb.latchClr = 1'b1;
        default:   ;
      endcase
    end
  end

  // Read select.
  always_comb begin
    case (funcSel)
      F_IRQ:               rdVec = view.irqStat;
      F_FIQ:               rdVec = view.fiqStat;
      F_RAW:               rdVec = view.pend;
      F_SEL:               rdVec = view.sel;
      F_EN_SET, F_EN_CLR:  rdVec = view.en;
      F_TRG_SET, F_TRG_CLR: rdVec = view.trg;
      F_SENSE:             rdVec = view.sense;
      F_DUAL:              rdVec = view.dual;
      F_POL:               rdVec = view.pol;
      F_LCLR, F_LSTAT:     rdVec = view.latch;
      default:             rdVec = '0;
    endcase
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_rd
    assign rdWords[w] = rdVec[w*WORD_W +: WORD_W];
  end

  assign rdData = addrOk ? rdWords[wordIdx] : '0;

endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter logic [NUM_SRC-1:0] SENSE_RST = 64'h0000_FFFF_0000_FFFF,
  parameter logic [NUM_SRC-1:0] POL_RST   = 64'hFFFF_FFFF_FFFF_FFFF,
  parameter logic [NUM_SRC-1:0] DUAL_RST  = 64'h0000_0000_0000_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WORD_W-1:0]  wrData,
  output logic [WORD_W-1:0]  rdData,
  output logic               irqOut,
  output logic               fiqOut
);

  strobe_t strb;
  view_t   regView;

  intc_ctrl u_ctrl (
    .wrEn  (wrEn),
    .addr  (addr),
    .wrData(wrData),
    .view  (regView),
    .strb  (strb),
    .rdData(rdData)
  );

  intc_datapath #(
    .SENSE_RST(SENSE_RST),
    .POL_RST  (POL_RST),
    .DUAL_RST (DUAL_RST)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .srcIn (srcIn),
    .strb  (strb),
    .view  (regView),
    .irqOut(irqOut),
    .fiqOut(fiqOut)
  );

endmodule

// File: rtl/intc_regs_chk.sv
module intc_regs_chk
  import intc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [WORD_W-1:0]  wrData,
  input logic               irqOut,
  input logic               fiqOut,
  input logic [NUM_SRC-1:0] enV,
  input logic [NUM_SRC-1:0] trgV,
  input logic [NUM_SRC-1:0] senseV,
  input logic [NUM_SRC-1:0] latchV,
  input logic [NUM_SRC-1:0] pendV,
  input logic [NUM_SRC-1:0] irqStatV,
  input logic [NUM_SRC-1:0] fiqStatV
);

  // R3: low-word enable set takes effect on the next edge
  p_enable_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h20) |=> ((enV[WORD_W-1:0] & $past(wrData)) == $past(wrData)));

  // R3: low-word enable clear takes effect on the next edge
  p_enable_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h28) |=> ((enV[WORD_W-1:0] & $past(wrData)) == '0));

  // R4: a triggered source is always pending
  p_trig_pending_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((pendV & trgV) == trgV));

  // R5: no source is routed to both outputs
  p_route_disjoint_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((irqStatV & fiqStatV) == '0));

  // R6: a level source never gains a latch bit
  p_level_no_latch_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((latchV & ~$past(latchV) & $past(senseV)) == '0));

  // R7: latches only drop through a latch-clear write
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr[6:3] == 4'd11) |=> ((latchV & $past(latchV)) == $past(latchV)));

  // R10: a request needs at least one enabled source
  p_out_enable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut || fiqOut) |-> (enV != '0));

endmodule

bind intc_regs intc_regs_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrData  (wrData),
  .irqOut  (irqOut),
  .fiqOut  (fiqOut),
  .enV     (regView.en),
  .trgV    (regView.trg),
  .senseV  (regView.sense),
  .latchV  (regView.latch),
  .pendV   (regView.pend),
  .irqStatV(regView.irqStat),
  .fiqStatV(regView.fiqStat)
);

// File: tb/sim_intc_regs.sv
`timescale 1ns/1ps
module sim_intc_regs;
  import intc_pkg::*;

  localparam logic [63:0] SENSE_INIT = 64'h0000_FFFF_0000_FFFF;
  localparam logic [63:0] POL_INIT   = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] DUAL_INIT  = 64'h0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] srcIn = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut, fiqOut;

  always #2.5 clk = ~clk;

  intc_regs #(.SENSE_RST(SENSE_INIT), .POL_RST(POL_INIT), .DUAL_RST(DUAL_INIT)) u0 (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  int nChecks = 0;
  int nFail = 0;

  logic [63:0] mEn, mTrg, mSel, mSense, mDual, mPol, mLatch, mPin;

  function automatic logic [63:0] expPend();
    return (mSense & ~(mPin ^ mPol)) | (~mSense & mLatch) | mTrg;
  endfunction

  function automatic logic [63:0] expFor(func_e f);
    case (f)
      F_IRQ:                return expPend() & mEn & ~mSel;
      F_FIQ:                return expPend() & mEn & mSel;
      F_RAW:                return expPend();
      F_SEL:                return mSel;
      F_EN_SET, F_EN_CLR:   return mEn;
      F_TRG_SET, F_TRG_CLR: return mTrg;
      F_SENSE:              return mSense;
      F_DUAL:               return mDual;
      F_POL:                return mPol;
      default:              return mLatch;
    endcase
  endfunction

  function automatic string tagFor(func_e f);
    case (f)
      F_IRQ, F_FIQ, F_SEL:  return "R5";
      F_RAW:                return "R11";
      F_EN_SET, F_EN_CLR:   return "R3";
      F_TRG_SET, F_TRG_CLR: return "R4";
      F_DUAL:               return "R8";
      F_LCLR:               return "R9";
      F_LSTAT:              return "R7";
      default:              return "R2";
    endcase
  endfunction

  task automatic checkVal(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rdAddr(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b0;
    addr = a;
    #1 d = rdData;
  endtask

  task automatic rdFunc(input func_e f, output logic [63:0] v);
    logic [31:0] lo, hi;
    rdAddr(8'(int'(f) << 3), lo);
    rdAddr(8'((int'(f) << 3) | 4), hi);
    v = {hi, lo};
  endtask

  task automatic checkAll(string ctx);
    logic [63:0] v;
    for (int i = 0; i <= LAST_FUNC; i++) begin
      rdFunc(func_e'(i), v);
      checkVal(tagFor(func_e'(i)), $sformatf("%s func %0d", ctx, i), v, expFor(func_e'(i)));
    end
    checkVal("R10", {ctx, " irqOut"}, {63'd0, irqOut}, {63'd0, |expFor(F_IRQ)});
    checkVal("R10", {ctx, " fiqOut"}, {63'd0, fiqOut}, {63'd0, |expFor(F_FIQ)});
  endtask

  task automatic wrRaw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    addr = a;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wrReg(input func_e f, input int w, input logic [31:0] d);
    logic [63:0] m, ws;
    m  = (w != 0) ? {d, 32'h0} : {32'h0, d};
    ws = (w != 0) ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
    wrRaw(8'((int'(f) << 3) | (w << 2)), d);
    case (f)
      F_SEL:     mSel   = (mSel & ~ws) | m;
      F_SENSE:   mSense = (mSense & ~ws) | m;
      F_DUAL:    mDual  = (mDual & ~ws) | m;
      F_POL:     mPol   = (mPol & ~ws) | m;
      F_EN_SET:  mEn    = mEn | m;
      F_EN_CLR:  mEn    = mEn & ~m;
      F_TRG_SET: mTrg   = mTrg | m;
      F_TRG_CLR: mTrg   = mTrg & ~m;
      F_LCLR:    mLatch = mLatch & ~(m & ~mSense);
      default:   ;
    endcase
  endtask

  task automatic setPins(input logic [63:0] nv);
    logic [63:0] rise, fall, hit;
    rise = nv & ~mPin;
    fall = ~nv & mPin;
    hit  = (mDual & (rise | fall)) | (~mDual & mPol & rise) | (~mDual & ~mPol & fall);
    mLatch = mLatch | (hit & ~mSense);
    mPin = nv;
    @(negedge clk);
    srcIn = nv;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [31:0] d;
    func_e wlist [9];
    wlist = '{F_SEL, F_EN_SET, F_EN_CLR, F_TRG_SET, F_TRG_CLR, F_SENSE, F_DUAL, F_POL, F_LCLR};
    void'($urandom(32'd4242));
    mEn = '0; mTrg = '0; mSel = '0; mLatch = '0; mPin = '0;
    mSense = SENSE_INIT; mPol = POL_INIT; mDual = DUAL_INIT;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    checkAll("R1 reset");
    rdFunc(F_SENSE, v);
    checkVal("R1", "sense reset", v, SENSE_INIT);

    // R3: set/clear with zero bits untouched
    wrReg(F_EN_SET, 0, 32'h0000_00F0);
    wrReg(F_EN_SET, 0, 32'h0000_000F);
    rdFunc(F_EN_SET, v);
    checkVal("R3", "enable after two sets", v, 64'hFF);
    wrReg(F_EN_CLR, 0, 32'h0000_0030);
    rdFunc(F_EN_CLR, v);
    checkVal("R3", "enable after clear", v, 64'hCF);

    // R4: soft trigger on an inactive level source
    wrReg(F_TRG_SET, 0, 32'h8);
    rdFunc(F_RAW, v);
    checkVal("R4", "raw with trigger", v, 64'h8);
    checkVal("R10", "irqOut with trigger", {63'd0, irqOut}, 64'd1);
    // R5: route to fast output
    wrReg(F_SEL, 0, 32'h8);
    rdFunc(F_FIQ, v);
    checkVal("R5", "fast status", v, 64'h8);
    checkVal("R5", "irqOut while routed fast", {63'd0, irqOut}, 64'd0);
    wrReg(F_TRG_CLR, 0, 32'h8);
    checkVal("R4", "fiqOut after trigger clear", {63'd0, fiqOut}, 64'd0);
    wrReg(F_SEL, 0, 32'h0);

    // R6: level latency, source 1
    @(negedge clk);
    srcIn[1] = 1'b1;
    mPin[1] = 1'b1;
    rdAddr(8'h10, d);
    checkVal("R6", "level after one edge", {32'd0, d}, 64'h0);
    rdAddr(8'h10, d);
    checkVal("R6", "level after two edges", {32'd0, d}, 64'h2);
    rdFunc(F_LSTAT, v);
    checkVal("R6", "level source latch", v, 64'h0);
    // R9: latch clear is ignored for a level source
    wrReg(F_LCLR, 0, 32'h2);
    rdAddr(8'h10, d);
    checkVal("R9", "level pending after clear", {32'd0, d}, 64'h2);
    setPins(mPin & ~64'h2);
    wrReg(F_POL, 0, 32'hFFFF_FFFD);
    checkAll("R6 active-low");
    wrReg(F_POL, 0, 32'hFFFF_FFFF);

    // R7: edge latency, source 16
    wrReg(F_EN_SET, 0, 32'h0001_0000);
    @(negedge clk);
    srcIn[16] = 1'b1;
    mPin[16] = 1'b1;
    rdAddr(8'h60, d);
    checkVal("R7", "latch after one edge", {32'd0, d}, 64'h0);
    rdAddr(8'h60, d);
    checkVal("R7", "latch after two edges", {32'd0, d}, 64'h0);
    rdAddr(8'h60, d);
    checkVal("R7", "latch after three edges", {32'd0, d}, 64'h0001_0000);
    mLatch[16] = 1'b1;
    setPins(mPin & ~(64'h1 << 16));
    checkVal("R7", "irqOut held by latch", {63'd0, irqOut}, 64'd1);
    wrReg(F_LCLR, 0, 32'h0001_0000);
    checkAll("R9 clear");

    // R8: falling polarity and both edges
    wrReg(F_POL, 0, 32'hFFFD_FFFF);
    setPins(mPin | (64'h1 << 17));
    rdFunc(F_LSTAT, v);
    checkVal("R8", "falling source on rise", v, 64'h0);
    setPins(mPin & ~(64'h1 << 17));
    rdFunc(F_LSTAT, v);
    checkVal("R7", "falling source on fall", v, 64'h1 << 17);
    wrReg(F_DUAL, 0, 32'h0004_0000);
    setPins(mPin | (64'h1 << 18));
    wrReg(F_LCLR, 0, 32'h0006_0000);
    setPins(mPin & ~(64'h1 << 18));
    rdFunc(F_LSTAT, v);
    checkVal("R8", "both-edge source on fall", v, 64'h1 << 18);
    wrReg(F_LCLR, 0, 32'h0004_0000);
    checkAll("R8");

    // R9: clear lands on the edge that detects a new transition
    @(negedge clk);
    srcIn[16] = 1'b1;
    mPin[16] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wrEn = 1'b1; addr = 8'h58; wrData = 32'h0001_0000;
    @(negedge clk);
    wrEn = 1'b0;
    mLatch[16] = 1'b1;
    rdFunc(F_LSTAT, v);
    checkVal("R9", "edge wins over clear", v, 64'h1 << 16);
    wrReg(F_LCLR, 0, 32'h0001_0000);

    // R2/R10: high word independent of low word
    wrReg(F_EN_CLR, 0, 32'hFFFF_FFFF);
    wrReg(F_EN_SET, 1, 32'h0001_0000);
    setPins(mPin | (64'h1 << 48));
    wrReg(F_LCLR, 0, 32'h0001_0000);
    rdFunc(F_LSTAT, v);
    checkVal("R2", "low clear spares source 48", v, 64'h1 << 48);
    checkVal("R10", "irqOut from high word", {63'd0, irqOut}, 64'd1);
    wrReg(F_LCLR, 1, 32'h0001_0000);
    checkVal("R10", "irqOut after high clear", {63'd0, irqOut}, 64'd0);

    // R12: ignored writes and zero reads
    wrRaw(8'h00, 32'hFFFF_FFFF);
    wrRaw(8'h68, 32'hFFFF_FFFF);
    wrRaw(8'h7C, 32'hFFFF_FFFF);
    wrRaw(8'h21, 32'hFFFF_FFFF);
    wrRaw(8'hA0, 32'hFFFF_FFFF);
    wrRaw(8'hB0, 32'hFFFF_FFFF);
    checkAll("R12 after ignored writes");
    rdAddr(8'h68, d);
    checkVal("R12", "read 0x68", {32'd0, d}, 64'h0);
    rdAddr(8'hA0, d);
    checkVal("R12", "read 0xA0", {32'd0, d}, 64'h0);
    rdAddr(8'h22, d);
    checkVal("R12", "read 0x22", {32'd0, d}, 64'h0);

    // Random traffic
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 6) begin
        func_e f;
        logic [31:0] dd;
        f = wlist[$urandom_range(0, 8)];
        dd = $urandom;
        if (f == F_TRG_SET || f == F_EN_SET) dd = dd & $urandom & $urandom;
        wrReg(f, $urandom_range(0, 1), dd);
      end else begin
        logic [63:0] fl;
        fl = {$urandom & $urandom, $urandom & $urandom};
        setPins(mPin ^ fl);
      end
      checkAll($sformatf("random %0d", it));
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule